// File: doc/BRIEF.md
# Four-Bank DDR SDRAM Command Timing Checker

This block watches the command bus of a four-bank DDR SDRAM. It samples chip select, the three command strobes, the two bank-select bits and address bit 10 once per rising clock edge. From these it keeps an idle or active state for each bank, along with a set of interval counters. When a command would break a minimum spacing rule, or does not fit the current state of its bank, the block raises a one-cycle violation pulse. The pulse carries a violation code and the index of the bank involved. The block only observes the bus and never alters it, and it keeps checking after it reports a violation.

Every timing limit is a parameter given in clock cycles. The defaults assume a 7.5 ns clock: activate-to-column 3, precharge-to-activate 3, activate-to-activate across banks 2, activate-to-activate or refresh in the same bank 9, minimum row-open time 6, write recovery 2, and auto-precharge write-to-activate 5. A separate, large parameter bounds how long a row may stay open. The block covers plain and auto-precharge column commands, and both single-bank and all-bank precharge. It does not cover the data path, strobes, mode register contents or refresh scheduling.

Top module: `ddr_timing_checker`

## Requirements
- R1: The block samples a command on a rising edge only when `cs_n` is low. The command is decoded from {`ras_n`,`cas_n`,`we_n`]: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, all others no check. While `cs_n` is high, no command violation is raised, but the bank counters keep running.
- R2: The bank index is {BA0, BA1}, where BA1 is `ba[1]` and BA0 is `ba[0]`. So `ba`=2'b01 selects bank 2 and `ba`=2'b10 selects bank 1.
- R3: The outputs are registered. A violation found at an edge drives `viol_valid`=1 for exactly the following cycle, with `viol_code` and `viol_bank`. Otherwise `viol_valid`=0 and `viol_code`=0. The codes are: 1 bank state, 2 activate-to-column, 3 precharge-to-activate, 4 cross-bank activate spacing, 5 same-bank activate/refresh spacing, 6 row open too short, 7 write recovery, 8 auto-precharge write recovery, 9 row open too long. After reset all banks are idle and no violation is pending.
- R4: A read or write to an idle bank, an activate to an active bank, and a refresh while any bank is active each give code 1.
- R5: A read or write fewer than T_RCD cycles after the activate of its bank gives code 2.
- R6: An activate fewer than T_RRD cycles after the most recent activate to a different bank gives code 4.
- R7: An activate to a bank, or a refresh, fewer than T_RC cycles after that bank's last activate gives code 5.
- R8: An activate or refresh fewer than T_RP cycles after the bank was closed by a precharge or an auto-precharge read gives code 3.
- R9: A precharge that closes a bank fewer than T_RAS_MIN cycles after its activate gives code 6. If the row-open time is met but the bank's last write is fewer than T_WR cycles back, the code is 7.
- R10: A precharge with `a10`=1 closes every active bank. With `a10`=0 it closes only the addressed bank. A precharge to an idle bank has no effect.
- R11: A read or write with `a10`=1 closes its bank at that command. After an auto-precharge write, an activate to that bank fewer than T_DAL cycles later gives code 8.
- R12: A bank left active for more than T_RAS_MAX cycles produces one code 9 pulse, on the edge T_RAS_MAX+1 cycles after its activate. A precharge exactly T_RAS_MAX cycles after the activate is legal.
- R13: When one command breaks several rules, the order is: state, then tRC, then precharge/auto-precharge recovery, then tRRD. For a precharge, row-open time is checked before write recovery. Across several banks, the lowest bank index is reported. A command violation hides a same-cycle code 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank-select bits, ba[1]=BA1, ba[0]=BA0 |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Violation type code |
| viol_bank | output | 2 | Bank index of the violation |

## Verification
The embedded assertions check four things on every cycle. First, a bank only opens after an activate event and only closes after a precharge-type event. Second, a row-open expiry pulses just once. Third, a deselected cycle never yields a command violation. Fourth, a read to an idle bank always reports a state violation on the next cycle. The directed scenarios cover what the assertions cannot: the exact cycle counts at each interval boundary, both just short and just met; the swapped bank-bit decoding; the choice between all-bank and single-bank precharge; tDAL after an auto-precharge write; and the priority when a command breaks several rules or touches several banks.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

    localparam int NBANK = 4;
    localparam int BW    = 2;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE   = 4'd0,
        V_STATE  = 4'd1,
        V_RCD    = 4'd2,
        V_RP     = 4'd3,
        V_RRD    = 4'd4,
        V_RC     = 4'd5,
        V_RASMIN = 4'd6,
        V_WR     = 4'd7,
        V_DAL    = 4'd8,
        V_RASMAX = 4'd9
    } viol_e;

    typedef struct packed {
        viol_e           code;
        logic [BW-1:0]   bank;
    } viol_t;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        if (cs_n) return CMD_NOP;
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            3'b110:  return CMD_BST;
            default: return CMD_NOP;
        endcase
    endfunction

    // BA0 is the high bit of the bank index
    function automatic logic [BW-1:0] bank_of(input logic [1:0] ba);
        return {ba[0], ba[1]};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_bank_state.sv
module ddr_bank_state #(
    parameter int TW        = 4,
    parameter int RW        = 15,
    parameter int T_RAS_MAX = 16000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_act,
    input  logic          ev_close,
    input  logic          ev_close_dal,
    input  logic          ev_wr,
    output logic          active,
    output logic [TW-1:0] act_age,
    output logic [TW-1:0] gate_age,
    output logic          gate_dal,
    output logic [TW-1:0] wr_age,
    output logic          ras_expired
);
    localparam logic [TW-1:0] TSAT     = '1;
    localparam logic [RW-1:0] OPEN_LIM = RW'(T_RAS_MAX + 1);
    localparam logic [RW-1:0] OPEN_SAT = RW'(T_RAS_MAX + 2);

    logic [RW-1:0] open_cnt;

    function automatic logic [TW-1:0] inc(input logic [TW-1:0] v);
        return (v == TSAT) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            act_age  <= TSAT;
            gate_age <= TSAT;
            gate_dal <= 1'b0;
            wr_age   <= TSAT;
            open_cnt <= OPEN_SAT;
        end else begin
            act_age  <= ev_act ? TW'(1) : inc(act_age);
            wr_age   <= ev_wr  ? TW'(1) : inc(wr_age);
            if (ev_act)
                open_cnt <= RW'(1);
            else if (open_cnt != OPEN_SAT)
                open_cnt <= open_cnt + 1'b1;
            if (ev_act)
                active <= 1'b1;
            else if (ev_close || ev_close_dal)
                active <= 1'b0;
            if (ev_close || ev_close_dal) begin
                gate_age <= TW'(1);
                gate_dal <= ev_close_dal;
            end else begin
                gate_age <= inc(gate_age);
            end
        end
    end

    assign ras_expired = active && (open_cnt == OPEN_LIM);

    assert_open_on_act_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(ev_act));
    assert_close_on_pre_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(ev_close || ev_close_dal));
    assert_expire_once_R12: assert property (@(posedge clk) disable iff (rst)
        ras_expired |=> !ras_expired);

endmodule

// File: rtl/ddr_rule_eval.sv
module ddr_rule_eval
    import ddr_chk_pkg::*;
#(
    parameter int TW        = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 9,
    parameter int T_RAS_MIN = 6,
    parameter int T_WR      = 2,
    parameter int T_DAL     = 5
) (
    input  cmd_e                      cmd,
    input  logic [BW-1:0]             bank,
    input  logic                      a10,
    input  logic [NBANK-1:0]          active,
    input  logic [NBANK-1:0][TW-1:0]  act_age,
    input  logic [NBANK-1:0][TW-1:0]  gate_age,
    input  logic [NBANK-1:0]          gate_dal,
    input  logic [NBANK-1:0][TW-1:0]  wr_age,
    input  logic [NBANK-1:0]          ras_expired,
    input  logic [TW-1:0]             last_act_age,
    input  logic [BW-1:0]             last_act_bank,
    output viol_t                     result
);
    localparam logic [TW-1:0] L_RCD = TW'(T_RCD);
    localparam logic [TW-1:0] L_RP  = TW'(T_RP);
    localparam logic [TW-1:0] L_RRD = TW'(T_RRD);
    localparam logic [TW-1:0] L_RC  = TW'(T_RC);
    localparam logic [TW-1:0] L_RAS = TW'(T_RAS_MIN);
    localparam logic [TW-1:0] L_WR  = TW'(T_WR);
    localparam logic [TW-1:0] L_DAL = TW'(T_DAL);

    function automatic logic gate_short(input logic [TW-1:0] age, input logic dal);
        return age < (dal ? L_DAL : L_RP);
    endfunction

    always_comb begin
        result = '{code: V_NONE, bank: '0};
        case (cmd)
            CMD_ACT: begin
                if (active[bank])
                    result = '{code: V_STATE, bank: bank};
                else if (act_age[bank] < L_RC)
                    result = '{code: V_RC, bank: bank};
                else if (gate_short(gate_age[bank], gate_dal[bank]))
                    result = '{code: gate_dal[bank] ? V_DAL : V_RP, bank: bank};
                else if (last_act_bank != bank && last_act_age < L_RRD)
                    result = '{code: V_RRD, bank: bank};
            end
            CMD_RD, CMD_WR: begin
                if (!active[bank])
                    result = '{code: V_STATE, bank: bank};
                else if (act_age[bank] < L_RCD)
                    result = '{code: V_RCD, bank: bank};
            end
            CMD_PRE: begin
                for (int b = NBANK - 1; b >= 0; b--) begin
                    if ((a10 || BW'(b) == bank) && active[b]) begin
                        if (act_age[b] < L_RAS)
                            result = '{code: V_RASMIN, bank: BW'(b)};
                        else if (wr_age[b] < L_WR)
                            result = '{code: V_WR, bank: BW'(b)};
                    end
                end
            end
            CMD_REF: begin
                if (|active) begin
                    for (int b = NBANK - 1; b >= 0; b--)
                        if (active[b]) result = '{code: V_STATE, bank: BW'(b)};
                end else begin
                    for (int b = NBANK - 1; b >= 0; b--) begin
                        if (act_age[b] < L_RC)
                            result = '{code: V_RC, bank: BW'(b)};
                        else if (gate_short(gate_age[b], gate_dal[b]))
                            result = '{code: gate_dal[b] ? V_DAL : V_RP, bank: BW'(b)};
                    end
                end
            end
            default: result = '{code: V_NONE, bank: '0};
        endcase
        if (result.code == V_NONE) begin
            for (int b = NBANK - 1; b >= 0; b--)
                if (ras_expired[b]) result = '{code: V_RASMAX, bank: BW'(b)};
        end
    end

endmodule

// File: rtl/ddr_timing_checker.sv
module ddr_timing_checker
    import ddr_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 9,
    parameter int T_RAS_MIN = 6,
    parameter int T_WR      = 2,
    parameter int T_DAL     = 5,
    parameter int T_RAS_MAX = 16000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output logic       viol_valid,
    output logic [3:0] viol_code,
    output logic [1:0] viol_bank
);
    localparam int SHORT_MAX = imax(imax(imax(T_RCD, T_RP), imax(T_RRD, T_RC)),
                                    imax(imax(T_RAS_MIN, T_WR), T_DAL));
    localparam int TW = $clog2(SHORT_MAX + 1);
    localparam int RW = $clog2(T_RAS_MAX + 3);
    localparam logic [TW-1:0] TSAT = '1;

    cmd_e          cmd;
    logic [BW-1:0] bank;

    logic [NBANK-1:0]         active, gate_dal, ras_expired;
    logic [NBANK-1:0][TW-1:0] act_age, gate_age, wr_age;
    logic [NBANK-1:0]         ev_act, ev_close, ev_close_dal, ev_wr;
    logic [TW-1:0]            last_act_age;
    logic [BW-1:0]            last_act_bank;
    viol_t                    found, viol_q;

    assign cmd  = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign bank = bank_of(ba);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel             = (bank == BW'(b));
        assign ev_act[b]       = (cmd == CMD_ACT) && sel;
        assign ev_wr[b]        = (cmd == CMD_WR) && sel && active[b];
        assign ev_close[b]     = active[b] &&
                                 (((cmd == CMD_PRE) && (a10 || sel)) ||
                                  ((cmd == CMD_RD) && sel && a10));
        assign ev_close_dal[b] = active[b] && (cmd == CMD_WR) && sel && a10;

        ddr_bank_state #(.TW(TW), .RW(RW), .T_RAS_MAX(T_RAS_MAX)) u_state (
            .clk          (clk),
            .rst          (rst),
            .ev_act       (ev_act[b]),
            .ev_close     (ev_close[b]),
            .ev_close_dal (ev_close_dal[b]),
            .ev_wr        (ev_wr[b]),
            .active       (active[b]),
            .act_age      (act_age[b]),
            .gate_age     (gate_age[b]),
            .gate_dal     (gate_dal[b]),
            .wr_age       (wr_age[b]),
            .ras_expired  (ras_expired[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_act_age  <= TSAT;
            last_act_bank <= '0;
        end else if (cmd == CMD_ACT) begin
            last_act_age  <= TW'(1);
            last_act_bank <= bank;
        end else if (last_act_age != TSAT) begin
            last_act_age  <= last_act_age + 1'b1;
        end
    end

    ddr_rule_eval #(
        .TW(TW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
        .T_RAS_MIN(T_RAS_MIN), .T_WR(T_WR), .T_DAL(T_DAL)
    ) u_eval (
        .cmd           (cmd),
        .bank          (bank),
        .a10           (a10),
        .active        (active),
        .act_age       (act_age),
        .gate_age      (gate_age),
        .gate_dal      (gate_dal),
        .wr_age        (wr_age),
        .ras_expired   (ras_expired),
        .last_act_age  (last_act_age),
        .last_act_bank (last_act_bank),
        .result        (found)
    );

    always_ff @(posedge clk) begin
        if (rst) viol_q <= '{code: V_NONE, bank: '0};
        else     viol_q <= found;
    end

    assign viol_valid = (viol_q.code != V_NONE);
    assign viol_code  = viol_q.code;
    assign viol_bank  = viol_q.bank;

    assert_cs_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && viol_valid) |-> (viol_code == V_RASMAX));
    assert_rd_idle_R4: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD) && !active[bank]) |=>
            (viol_valid && viol_code == V_STATE));

endmodule

// File: tb/ddr_timing_checker_bench.sv
module ddr_timing_checker_bench;

    localparam int RASMAX = 40;
    localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                           P_PRE = 3'b010, P_REF = 3'b001, P_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'b00;
    logic       viol_valid;
    logic [3:0] viol_code;
    logic [1:0] viol_bank;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic       got_v;
    logic [3:0] got_c;
    logic [1:0] got_b;

    always #10 clk = ~clk;

    ddr_timing_checker #(.T_RAS_MAX(RASMAX)) u_ddr_timing_checker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10),
        .viol_valid(viol_valid), .viol_code(viol_code), .viol_bank(viol_bank)
    );

    task automatic step(input logic csn, input logic [2:0] rcw,
                        input logic [1:0] braw, input logic a);
        @(negedge clk);
        cs_n = csn; {ras_n, cas_n, we_n} = rcw; ba = braw; a10 = a;
        @(posedge clk);
        #2;
        got_v = viol_valid; got_c = viol_code; got_b = viol_bank;
    endtask

    // bank index {BA0,BA1} -> ba = {BA1,BA0}
    task automatic cmd(input logic [2:0] rcw, input logic [1:0] bk, input logic a);
        step(1'b0, rcw, {bk[0], bk[1]}, a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, P_NOP, 2'b00, 1'b0);
    endtask

    task automatic check(input string req, input logic [3:0] ec, input logic [1:0] eb);
        logic ev;
        ev = (ec != 4'd0);
        checks++;
        if (got_v !== ev || got_c !== ec || (ev && got_b !== eb)) begin
            errors++;
            $display("FAIL %s: got valid=%0b code=%0d bank=%0d, expected valid=%0b code=%0d bank=%0d",
                     req, got_v, got_c, got_b, ev, ec, eb);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP;
        repeat (3) @(negedge clk);
        checks++;
        if (viol_valid !== 1'b0 || viol_code !== 4'd0) begin
            errors++;
            $display("FAIL R3 reset: got valid=%0b code=%0d, expected 0/0", viol_valid, viol_code);
        end
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        idle(1); check("R3 idle after reset", 0, 0);
    endtask

    task automatic t_cs();
        do_reset();
        step(1'b1, P_RD, 2'b00, 1'b0); check("R1 deselected read ignored", 0, 0);
        step(1'b1, P_WR, 2'b11, 1'b0); check("R1 deselected write ignored", 0, 0);
    endtask

    task automatic t_illegal();
        do_reset();
        cmd(P_RD, 2'd0, 0); check("R4 read idle bank", 1, 0);
        cmd(P_WR, 2'd3, 0); check("R4 write idle bank", 1, 3);
        cmd(P_ACT, 2'd1, 0); check("R4 activate ok", 0, 0);
        idle(9);
        cmd(P_ACT, 2'd1, 0); check("R4 activate active bank", 1, 1);
        cmd(P_REF, 2'd0, 0); check("R4 refresh with bank open", 1, 1);
    endtask

    task automatic t_decode();
        do_reset();
        step(1'b0, P_ACT, 2'b01, 1'b0); check("R2 activate ba=01", 0, 0);
        step(1'b0, P_RD, 2'b01, 1'b0);  check("R2 ba=01 is bank 2 (tRCD)", 2, 2);
        step(1'b0, P_RD, 2'b10, 1'b0);  check("R2 ba=10 is bank 1 (idle)", 1, 1);
    endtask

    task automatic t_trcd();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(1);
        cmd(P_RD, 2'd0, 0); check("R5 read 2 cycles after activate", 2, 0);
        cmd(P_WR, 2'd0, 0); check("R5 write 3 cycles after activate", 0, 0);
    endtask

    task automatic t_trrd();
        do_reset();
        cmd(P_ACT, 2'd0, 0);
        cmd(P_ACT, 2'd1, 0); check("R6 activate other bank after 1", 4, 1);
        idle(1);
        cmd(P_ACT, 2'd2, 0); check("R6 activate other bank after 2", 0, 0);
    endtask

    task automatic t_trc();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(5); cmd(P_PRE, 2'd0, 0); idle(1);
        cmd(P_ACT, 2'd0, 0); check("R7 re-activate after 8 (R13 before tRP)", 5, 0);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(5); cmd(P_PRE, 2'd0, 0); idle(2);
        cmd(P_ACT, 2'd0, 0); check("R7 re-activate after 9", 0, 0);
    endtask

    task automatic t_trp();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(6); cmd(P_PRE, 2'd0, 0); idle(1);
        cmd(P_ACT, 2'd0, 0); check("R8 activate 2 after precharge", 3, 0);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(7);
        cmd(P_RD, 2'd0, 1); check("R11 auto-precharge read", 0, 0);
        cmd(P_ACT, 2'd0, 0); check("R8 activate 1 after read-AP", 3, 0);
    endtask

    task automatic t_pre();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(4);
        cmd(P_PRE, 2'd0, 0); check("R9 precharge at 5 (tRAS)", 6, 0);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(4); cmd(P_WR, 2'd0, 0);
        cmd(P_PRE, 2'd0, 0); check("R9 precharge 1 after write", 7, 0);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(2); cmd(P_WR, 2'd0, 0);
        cmd(P_PRE, 2'd0, 0); check("R13 tRAS outranks tWR", 6, 0);
    endtask

    task automatic t_precharge_modes();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(1); cmd(P_ACT, 2'd3, 0); idle(5);
        cmd(P_PRE, 2'd1, 1); check("R10 precharge all", 0, 0);
        cmd(P_RD, 2'd0, 0); check("R10 bank 0 closed by all", 1, 0);
        cmd(P_RD, 2'd3, 0); check("R10 bank 3 closed by all", 1, 3);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(1); cmd(P_ACT, 2'd1, 0); idle(5);
        cmd(P_PRE, 2'd0, 0); check("R10 single precharge", 0, 0);
        cmd(P_RD, 2'd1, 0); check("R10 other bank still open", 0, 0);
        cmd(P_RD, 2'd0, 0); check("R10 addressed bank closed", 1, 0);
        cmd(P_PRE, 2'd2, 0); check("R10 precharge idle bank", 0, 0);
        cmd(P_RD, 2'd1, 0); check("R10 idle precharge left bank 1 open", 0, 0);
        do_reset();
        cmd(P_ACT, 2'd1, 0); idle(1); cmd(P_ACT, 2'd2, 0); idle(2);
        cmd(P_PRE, 2'd0, 1); check("R13 lowest bank reported", 6, 1);
    endtask

    task automatic t_wrap();
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(5);
        cmd(P_WR, 2'd0, 1); check("R11 auto-precharge write", 0, 0);
        cmd(P_RD, 2'd0, 0); check("R11 bank closed after write-AP", 1, 0);
        idle(1);
        cmd(P_ACT, 2'd0, 0); check("R11 activate 3 after write-AP", 8, 0);
        do_reset();
        cmd(P_ACT, 2'd0, 0); idle(5); cmd(P_WR, 2'd0, 1); idle(4);
        cmd(P_ACT, 2'd0, 0); check("R11 activate 5 after write-AP", 0, 0);
    endtask

    task automatic t_rasmax();
        int bad;
        bad = 0;
        do_reset();
        cmd(P_ACT, 2'd2, 0);
        for (int i = 1; i <= RASMAX; i++) begin
            step(1'b1, P_RD, 2'b00, 1'b0);
            if (got_v !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R12 early expiry: got %0d pulses, expected 0", bad);
        end
        idle(1); check("R12 row open too long", 9, 2);
        idle(1); check("R12 single pulse", 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cs();
        t_illegal();
        t_decode();
        t_trcd();
        t_trrd();
        t_trc();
        t_trp();
        t_pre();
        t_precharge_modes();
        t_wrap();
        t_rasmax();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule